// File: doc/BRIEF.md
# Complementary PWM Underflow Turnaround and Compare Reload

This block is the second timebase of a complementary PWM timer. It is a 16-bit up/down counter. It counts up to a programmable top value, then counts down. At the bottom it turns around through a wrapped value, so the counter shows 1, 0, FFFFh, 0, 1. The first crossing in that turnaround, from 0 to FFFFh, is the underflow point.

At the underflow point the block raises an underflow status flag. When the reload mode selects it, the block also copies three shadow compare registers into the active compare registers that the waveform logic reads. The copy happens in the same clock edge for all three registers. The second crossing, from FFFFh back to 0, does neither of these things. At the top turnaround the block raises an overflow flag. Software clears each flag with its own strobe.

Software loads the shadow registers at any time. The active registers change only at a qualifying underflow, so a partly written set of new compare values never reaches the outputs.

Top module: `cpwm_udf_reload`

## Requirements
- R1: When reset is applied, the counter, both flags, all three shadow registers and all three active registers are 0, and the counter then counts upward.
- R2: While `cnt_en` is high and the counter is not at a turnaround, the counter moves by one per clock in its current direction. While `cnt_en` is low, the counter and its direction hold.
- R3: When the counter is counting up and equals `top_val` with `cnt_en` high, the next value is `top_val`-1, counting then continues downward, and `ovf_flag` is set at that edge. `top_val` must lie between 1 and FFFEh.
- R4: When counting down, the counter passes through 1, 0, FFFFh, 0, 1 in that order, and then counts up.
- R5: `udf_flag` is set at the edge where the counter steps from 0 to FFFFh. The step from FFFFh to 0 does not set it.
- R6: When `reload_mode` equals 2'b10 at the 0-to-FFFFh edge, the active registers take their shadows at that single edge: active 0 from shadow 0, active 1 from shadow 1, active 2 from shadow 2.
- R7: No shadow-to-active copy happens at the FFFFh-to-0 step, at any other count, or at an underflow when `reload_mode` is not 2'b10. An underflow in such a mode still sets `udf_flag`.
- R8: `ovf_flag` is not changed by the underflow turnaround.
- R9: A flag is cleared only by a one-cycle pulse on its clear strobe (`udf_clr` or `ovf_clr`). When a set event and a clear strobe occur in the same cycle, the flag ends up set.
- R10: When bit i of `shadow_we` is high, shadow i loads `shadow_wdata` at the clock edge. Bit 0 selects shadow 0, bit 1 selects shadow 1 and bit 2 selects shadow 2. A shadow write does not change the active registers. A copy in the same cycle takes the shadow value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count enable |
| top_val | input | 16 | Upper turnaround value |
| reload_mode | input | 2 | Shadow-to-active copy mode; 2'b10 copies at underflow |
| shadow_we | input | 3 | Per-register shadow write enables |
| shadow_wdata | input | 16 | Shadow write data |
| udf_clr | input | 1 | Clear strobe for the underflow flag |
| ovf_clr | input | 1 | Clear strobe for the overflow flag |
| cnt_val | output | 16 | Counter value |
| act_cmp0 | output | 16 | Active compare register 0 |
| act_cmp1 | output | 16 | Active compare register 1 |
| act_cmp2 | output | 16 | Active compare register 2 |
| udf_flag | output | 1 | Underflow status flag |
| ovf_flag | output | 1 | Overflow status flag |

## Verification
Some rules are checked by assertions on every cycle. These are: the step after FFFFh is always 0, an underflow edge always lands on FFFFh, the active registers either hold or take the shadow values from the cycle before, and each flag follows its set and clear rules. The bench scenarios are needed for the full turnaround order, the direction reversal at the top value, and whether a copy happens in each reload mode. They also cover the coincidence of a shadow write with a copy, and the coincidence of a clear strobe with a set event. A reference model in the bench predicts each of these cycle by cycle.

// File: rtl/cpwm_pkg.sv
// Package: shared types and constants for the complementary PWM underflow reload block.
// Assumes: one counter direction state per timebase.
package cpwm_pkg;
    typedef enum logic [1:0] {
        DIR_UP   = 2'd0,
        DIR_DOWN = 2'd1,
        DIR_WRAP = 2'd2
    } cnt_dir_e;

    localparam logic [1:0] RELOAD_AT_UDF = 2'b10;
endpackage

// File: rtl/cpwm_updown_cnt.sv
// Module: up/down counter with a top reversal and a bottom turnaround through the all-ones value.
// Assumes: top_val lies in 1..2^W-2; all outputs are registered except the event pulses.
module cpwm_updown_cnt
    import cpwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] top_val,
    output logic [W-1:0] cnt_q,
    output logic         ovf_evt,
    output logic         udf_evt
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    cnt_dir_e     dir_q, dir_d;
    logic [W-1:0] cnt_d;

    // Next-state selection for the count and the direction.
    always_comb begin
        cnt_d   = cnt_q;
        dir_d   = dir_q;
        ovf_evt = 1'b0;
        udf_evt = 1'b0;
        if (en) begin
            unique case (dir_q)
                DIR_UP: begin
                    if (cnt_q == top_val) begin
                        cnt_d   = cnt_q - 1'b1;
                        dir_d   = DIR_DOWN;
                        ovf_evt = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                DIR_DOWN: begin
                    if (cnt_q == '0) begin
                        cnt_d   = ALL_ONES;
                        dir_d   = DIR_WRAP;
                        udf_evt = 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: begin
                    cnt_d = '0;
                    dir_d = DIR_UP;
                end
            endcase
        end
    end

    // Counter and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
        end
    end

    // R4: the wrapped value is always followed by zero.
    assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt_q == ALL_ONES) |=> (cnt_q == '0));

    // R3: the top value is within the legal range while counting.
    assert_top_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (top_val != '0 && top_val != ALL_ONES));
endmodule

// File: rtl/cpwm_flag.sv
// Module: sticky status flag, set by a hardware event, cleared by a software strobe.
// Assumes: the set event has priority over a coincident clear.
module cpwm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr,
    output logic flag_q
);
    // Flag register with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (set_evt) flag_q <= 1'b1;
        else if (clr)     flag_q <= 1'b0;
    end

    // R9: a set event always leaves the flag set.
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag_q);

    // R9: without a set event or a clear, the flag holds.
    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_evt && !clr) |=> $stable(flag_q));
endmodule

// File: rtl/cpwm_cmp_bank.sv
// Module: shadow and active compare register bank with an atomic shadow-to-active copy.
// Assumes: a copy reads shadow values from before any write in the same cycle.
module cpwm_cmp_bank #(
    parameter int W     = 16,
    parameter int N_REG = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_REG-1:0]         shadow_we,
    input  logic [W-1:0]             shadow_wdata,
    input  logic                     copy_en,
    output logic [N_REG-1:0][W-1:0]  active_q
);
    logic [N_REG-1:0][W-1:0] shadow_q;

    for (genvar g = 0; g < N_REG; g++) begin : g_slot
        // Shadow register loaded from the write port.
        always_ff @(posedge clk) begin
            if (!rst_n)            shadow_q[g] <= '0;
            else if (shadow_we[g]) shadow_q[g] <= shadow_wdata;
        end

        // Active register loaded from its shadow on a copy.
        always_ff @(posedge clk) begin
            if (!rst_n)       active_q[g] <= '0;
            else if (copy_en) active_q[g] <= shadow_q[g];
        end
    end

    // R6: after a copy every active register equals its prior shadow.
    assert_copy_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        copy_en |=> (active_q == $past(shadow_q)));

    // R7: without a copy the active registers hold.
    assert_active_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !copy_en |=> $stable(active_q));
endmodule

// File: rtl/cpwm_udf_reload.sv
// Module: top of the complementary PWM second timebase with underflow flag and compare reload.
// Assumes: rst_n is synchronous; software pulses the clear strobes for one cycle.
module cpwm_udf_reload
    import cpwm_pkg::*;
#(
    parameter int W     = 16,
    parameter int N_REG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [W-1:0]     top_val,
    input  logic [1:0]       reload_mode,
    input  logic [N_REG-1:0] shadow_we,
    input  logic [W-1:0]     shadow_wdata,
    input  logic             udf_clr,
    input  logic             ovf_clr,
    output logic [W-1:0]     cnt_val,
    output logic [W-1:0]     act_cmp0,
    output logic [W-1:0]     act_cmp1,
    output logic [W-1:0]     act_cmp2,
    output logic             udf_flag,
    output logic             ovf_flag
);
    logic                    ovf_evt, udf_evt, copy_en;
    logic [N_REG-1:0][W-1:0] active;

    cpwm_updown_cnt #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(cnt_en), .top_val(top_val),
        .cnt_q(cnt_val), .ovf_evt(ovf_evt), .udf_evt(udf_evt)
    );

    cpwm_flag u_udf (
        .clk(clk), .rst_n(rst_n), .set_evt(udf_evt), .clr(udf_clr), .flag_q(udf_flag)
    );

    cpwm_flag u_ovf (
        .clk(clk), .rst_n(rst_n), .set_evt(ovf_evt), .clr(ovf_clr), .flag_q(ovf_flag)
    );

    // Copy only on an underflow in the reload-at-underflow mode.
    assign copy_en = udf_evt && (reload_mode == RELOAD_AT_UDF);

    cpwm_cmp_bank #(.W(W), .N_REG(N_REG)) u_bank (
        .clk(clk), .rst_n(rst_n), .shadow_we(shadow_we), .shadow_wdata(shadow_wdata),
        .copy_en(copy_en), .active_q(active)
    );

    assign act_cmp0 = active[0];
    assign act_cmp1 = active[1];
    assign act_cmp2 = active[2];

    // R5: an underflow edge always lands the counter on the all-ones value.
    assert_udf_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        udf_evt |=> (cnt_val == {W{1'b1}}));

    // R8: the underflow turnaround leaves the overflow flag untouched.
    assert_udf_keeps_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (udf_evt && !ovf_clr) |=> $stable(ovf_flag));
endmodule

// File: tb/cpwm_udf_reload_bench.sv
module cpwm_udf_reload_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic [15:0] top_val = 16'd5;
    logic [1:0]  reload_mode = 2'b00;
    logic [2:0]  shadow_we = 3'b000;
    logic [15:0] shadow_wdata = 16'h0;
    logic        udf_clr = 1'b0;
    logic        ovf_clr = 1'b0;
    logic [15:0] cnt_val, act_cmp0, act_cmp1, act_cmp2;
    logic        udf_flag, ovf_flag;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [15:0] cnt;
        logic        udf;
        logic        ovf;
        logic [15:0] a0, a1, a2;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    // reference model state
    logic [15:0] m_cnt = 16'h0;
    int          m_dir = 0;
    logic        m_udf = 1'b0, m_ovf = 1'b0;
    logic [15:0] m_sh[3];
    logic [15:0] m_act[3];

    always #2.5 clk = ~clk;

    cpwm_udf_reload u_cpwm_udf_reload (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .top_val(top_val),
        .reload_mode(reload_mode), .shadow_we(shadow_we), .shadow_wdata(shadow_wdata),
        .udf_clr(udf_clr), .ovf_clr(ovf_clr), .cnt_val(cnt_val),
        .act_cmp0(act_cmp0), .act_cmp1(act_cmp1), .act_cmp2(act_cmp2),
        .udf_flag(udf_flag), .ovf_flag(ovf_flag)
    );

    task automatic check_now(input exp_t e);
        checks++;
        if (cnt_val !== e.cnt || udf_flag !== e.udf || ovf_flag !== e.ovf ||
            act_cmp0 !== e.a0 || act_cmp1 !== e.a1 || act_cmp2 !== e.a2) begin
            failures++;
            $display("FAIL %s: got cnt=%h udf=%b ovf=%b act=%h/%h/%h exp cnt=%h udf=%b ovf=%b act=%h/%h/%h",
                     e.tag, cnt_val, udf_flag, ovf_flag, act_cmp0, act_cmp1, act_cmp2,
                     e.cnt, e.udf, e.ovf, e.a0, e.a1, e.a2);
        end
    endtask

    // driver: applies one cycle of stimulus and pushes the predicted outcome
    task automatic drive(input logic en, input logic [1:0] mode, input logic [2:0] we,
                         input logic [15:0] wd, input logic cu, input logic co, input string tag);
        logic uevt, oevt;
        exp_t e;
        @(negedge clk);
        cnt_en = en; reload_mode = mode; shadow_we = we; shadow_wdata = wd;
        udf_clr = cu; ovf_clr = co;
        uevt = 1'b0; oevt = 1'b0;
        if (en) begin
            if (m_dir == 0) begin
                if (m_cnt == top_val) begin m_cnt = m_cnt - 16'd1; m_dir = 1; oevt = 1'b1; end
                else m_cnt = m_cnt + 16'd1;
            end else if (m_dir == 1) begin
                if (m_cnt == 16'd0) begin m_cnt = 16'hFFFF; m_dir = 2; uevt = 1'b1; end
                else m_cnt = m_cnt - 16'd1;
            end else begin
                m_cnt = 16'd0; m_dir = 0;
            end
        end
        if (uevt && mode == 2'b10) for (int i = 0; i < 3; i++) m_act[i] = m_sh[i];
        for (int i = 0; i < 3; i++) if (we[i]) m_sh[i] = wd;
        m_udf = uevt ? 1'b1 : (cu ? 1'b0 : m_udf);
        m_ovf = oevt ? 1'b1 : (co ? 1'b0 : m_ovf);
        e.cnt = m_cnt; e.udf = m_udf; e.ovf = m_ovf;
        e.a0 = m_act[0]; e.a1 = m_act[1]; e.a2 = m_act[2]; e.tag = tag;
        sb_q.push_back(e);
        @(posedge clk);
    endtask

    // monitor: compares outputs after each edge with the oldest prediction
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) check_now(sb_q.pop_front());
    end

    initial begin
        exp_t e0;
        for (int i = 0; i < 3; i++) begin m_sh[i] = 16'h0; m_act[i] = 16'h0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        e0.cnt = 16'h0; e0.udf = 1'b0; e0.ovf = 1'b0;
        e0.a0 = 16'h0; e0.a1 = 16'h0; e0.a2 = 16'h0; e0.tag = "R1 reset";
        check_now(e0);

        // R10: shadow loads while the counter holds (R2)
        drive(0, 2'b10, 3'b001, 16'h1111, 0, 0, "R10 load shadow0 R2 hold");
        drive(0, 2'b10, 3'b010, 16'h2222, 0, 0, "R10 load shadow1");
        drive(0, 2'b10, 3'b100, 16'h3333, 0, 0, "R10 load shadow2 actives unchanged");

        // R2 up count to top, R3 reversal with overflow
        for (int k = 0; k < 5; k++) drive(1, 2'b10, 3'b000, 16'h0, 0, 0, "R2 count up");
        drive(1, 2'b10, 3'b000, 16'h0, 0, 0, "R3 reverse at top ovf set");
        drive(0, 2'b10, 3'b000, 16'h0, 0, 0, "R2 hold while disabled");
        for (int k = 0; k < 3; k++) drive(1, 2'b10, 3'b000, 16'h0, 0, 0, "R4 count down");
        // now at 1 -> 0
        drive(1, 2'b10, 3'b000, 16'h0, 0, 0, "R4 reach zero");
        // R5/R6: 0 -> FFFF, copy, with a coincident shadow0 write (R10 old value copied)
        drive(1, 2'b10, 3'b001, 16'hAAAA, 0, 0, "R6 R5 underflow copy");
        drive(1, 2'b10, 3'b000, 16'h0, 0, 0, "R7 R4 FFFF to 0 no copy");
        drive(1, 2'b10, 3'b000, 16'h0, 0, 0, "R4 zero to one");
        drive(0, 2'b10, 3'b000, 16'h0, 1, 0, "R9 udf cleared by strobe R8 ovf kept");

        // second cycle in mode 01: udf set, no copy
        drive(0, 2'b00, 3'b110, 16'h5555, 0, 0, "R10 load shadows");
        for (int k = 0; k < 4; k++) drive(1, 2'b01, 3'b000, 16'h0, 0, 0, "R2 count up");
        drive(1, 2'b01, 3'b000, 16'h0, 0, 1, "R3 ovf set wins over clear R9");
        for (int k = 0; k < 4; k++) drive(1, 2'b01, 3'b000, 16'h0, 0, 0, "R4 count down");
        drive(1, 2'b01, 3'b000, 16'h0, 1, 0, "R7 mode01 udf set no copy R9 set wins");
        drive(1, 2'b01, 3'b000, 16'h0, 0, 0, "R7 no copy at FFFF to 0");
        drive(0, 2'b01, 3'b000, 16'h0, 0, 0, "R8 ovf unchanged by underflow");
        drive(0, 2'b00, 3'b000, 16'h0, 0, 1, "R9 ovf cleared by strobe");
        @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule